// File: doc/BRIEF.md
# Core-local timer and software interrupter

This block gives every hart of a small multi-core complex two machine-level interrupt sources. The first is a software interrupt: a single pending bit per hart that any core can set or clear by writing a word. The second is a timer interrupt: each hart has a 64-bit compare value, and its timer line is high whenever the shared 64-bit time counter has reached that value.

The time counter starts at zero after reset. A prescaler divides the system clock down to a fixed tick rate, and the counter advances by one on each tick. Software reaches all state through a plain 32-bit request/response port. Every 64-bit quantity appears as two little-endian 32-bit words. The bases of the software-interrupt, compare and time regions are parameters, and so is the hart count. Software moves a hart's compare value ahead of the current time to clear its timer interrupt. Writing a compare value that is already in the past raises the interrupt on the next cycle.

Top module: `core_timer_irq`

## Requirements
- R1: After reset, every software-interrupt bit is 0, every compare value is 0, the time counter is 0 and rsp_valid_o is 0.
- R2: A write to a hart's software-interrupt word sets its bit to (wdata_i != 0), and msip_o for that hart shows the new bit after the write's clock edge. A read of the word returns the bit in data bit 0 and zeros in bits 31:1.
- R3: The software-interrupt word of hart h sits at SW_BASE + 4*h.
- R4: The compare value of hart h sits at CMP_BASE + 8*h, with bits 31:0 at offset 0 and bits 63:32 at offset 4. A write to one half leaves the other half unchanged, and both halves can be read back.
- R5: mtip_o[h] is a register that, at each clock edge, loads the unsigned result (time >= compare_h). A compare value at or below the current time therefore raises the line one cycle after the write. Moving the compare value above the current time drops the line one cycle after the write.
- R6: The time counter increments by exactly 1 every CLK_HZ/TICK_HZ clock cycles (5 with the default parameters) and wraps modulo 2^64. Bits 31:0 read at TIME_BASE and bits 63:32 read at TIME_BASE + 4.
- R7: Bus writes to either time word have no effect on the counter.
- R8: A read of an unmapped address, or of an address with addr_i[1:0] != 0, returns 0. A write to such an address changes no state. This includes a hart index of NUM_HARTS or above.
- R9: rsp_valid_o is high for exactly the cycle after each accepted request (req_i high at a clock edge). rdata_o holds the read data registered at that edge, and it holds 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with rsp_valid_o |
| msip_o | output | NUM_HARTS | Software-interrupt line per hart |
| mtip_o | output | NUM_HARTS | Timer-interrupt line per hart |

## Verification
Read data and the response strobe are registered at the edge that samples the request, so the bench checks them at the following falling edge. The value read from the time counter is the count held before that edge, which is (edges since reset - 1) / 5. A software-interrupt write shows on msip_o at the falling edge right after the write edge. A compare write needs one further cycle before mtip_o reflects it, so after every access the bench idles one cycle before it checks mtip_o. At that point the expected level is ((edges - 1) / 5 >= compare). Random compare values are placed within a few ticks of the current time, so both the immediate-fire case and the delayed-rise case occur often.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_SW,
    RG_CMP_LO,
    RG_CMP_HI,
    RG_TIME_LO,
    RG_TIME_HI
  } region_e;
endpackage

// File: rtl/ctimer_tick_div.sv
module ctimer_tick_div #(
  parameter int unsigned PRESCALE = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (PRESCALE > 1) begin : g_gap
      // R6
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ctimer_time_cnt.sv
module ctimer_time_cnt (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  output logic [63:0] time_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_o <= '0;
    else if (tick_i) time_o <= time_o + 64'd1;
  end

  // R6
  time_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> time_o == $past(time_o) + 64'd1);
  // R7
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_o));
endmodule

// File: rtl/ctimer_decode.sv
module ctimer_decode
  import ctimer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned SW_BASE   = 32'h0000,
  parameter int unsigned CMP_BASE  = 32'h4000,
  parameter int unsigned TIME_BASE = 32'hBFF8,
  parameter int unsigned HART_W    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [HART_W-1:0] hart_o
);
  localparam logic [31:0] SW_SPAN  = 32'(4 * NUM_HARTS);
  localparam logic [31:0] CMP_SPAN = 32'(8 * NUM_HARTS);

  logic [31:0] a32, sw_off, cmp_off;

  always_comb begin
    a32      = 32'(addr_i);
    sw_off   = a32 - SW_BASE;
    cmp_off  = a32 - CMP_BASE;
    region_o = RG_NONE;
    hart_o   = '0;
    if (a32[1:0] != 2'b00) begin
      region_o = RG_NONE;
    end else if (a32 >= SW_BASE && sw_off < SW_SPAN) begin
      region_o = RG_SW;
      hart_o   = HART_W'(sw_off >> 2);
    end else if (a32 >= CMP_BASE && cmp_off < CMP_SPAN) begin
      region_o = cmp_off[2] ? RG_CMP_HI : RG_CMP_LO;
      hart_o   = HART_W'(cmp_off >> 3);
    end else if (a32 == TIME_BASE) begin
      region_o = RG_TIME_LO;
    end else if (a32 == TIME_BASE + 32'd4) begin
      region_o = RG_TIME_HI;
    end
  end
endmodule

// File: rtl/ctimer_hart_slot.sv
module ctimer_hart_slot (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] time_i,
  input  logic        sw_we_i,
  input  logic        cmp_lo_we_i,
  input  logic        cmp_hi_we_i,
  input  logic [31:0] wdata_i,
  output logic        msip_o,
  output logic        mtip_o,
  output logic [63:0] cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msip_o <= 1'b0;
      cmp_o  <= '0;
      mtip_o <= 1'b0;
    end else begin
      if (sw_we_i)     msip_o       <= (wdata_i != 32'd0);
      if (cmp_lo_we_i) cmp_o[31:0]  <= wdata_i;
      if (cmp_hi_we_i) cmp_o[63:32] <= wdata_i;
      mtip_o <= (time_i >= cmp_o);
    end
  end

  // R2
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> msip_o == ($past(wdata_i) != 32'd0));
  // R4
  cmp_hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_hi_we_i && !cmp_lo_we_i) |=> cmp_o[31:0] == $past(cmp_o[31:0]));
  // R4
  cmp_lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_lo_we_i && !cmp_hi_we_i) |=> cmp_o[63:32] == $past(cmp_o[63:32]));
  // R5
  mtip_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtip_o && !cmp_lo_we_i && !cmp_hi_we_i && !$past(cmp_lo_we_i || cmp_hi_we_i)
     && time_i != 64'd0) |=> mtip_o);
endmodule

// File: rtl/core_timer_irq.sv
module core_timer_irq
  import ctimer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned SW_BASE   = 32'h0000,
  parameter int unsigned CMP_BASE  = 32'h4000,
  parameter int unsigned TIME_BASE = 32'hBFF8,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned TICK_HZ   = 10_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          rdata_o,
  output logic [NUM_HARTS-1:0] msip_o,
  output logic [NUM_HARTS-1:0] mtip_o
);
  localparam int unsigned PRESCALE = CLK_HZ / TICK_HZ;
  localparam int unsigned HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic              tick;
  logic [63:0]       time_q;
  region_e           region;
  logic [HART_W-1:0] hart;
  logic [63:0]       cmp_q [NUM_HARTS];
  logic              wr, rd;
  logic [31:0]       rd_mux;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  ctimer_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ctimer_time_cnt u_time (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .time_o(time_q)
  );

  ctimer_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HARTS(NUM_HARTS),
    .SW_BASE  (SW_BASE),
    .CMP_BASE (CMP_BASE),
    .TIME_BASE(TIME_BASE),
    .HART_W   (HART_W)
  ) u_dec (
    .addr_i  (addr_i),
    .region_o(region),
    .hart_o  (hart)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel;
    assign sel = wr && (hart == HART_W'(h));
    ctimer_hart_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .time_i     (time_q),
      .sw_we_i    (sel && region == RG_SW),
      .cmp_lo_we_i(sel && region == RG_CMP_LO),
      .cmp_hi_we_i(sel && region == RG_CMP_HI),
      .wdata_i    (wdata_i),
      .msip_o     (msip_o[h]),
      .mtip_o     (mtip_o[h]),
      .cmp_o      (cmp_q[h])
    );
  end

  always_comb begin
    unique case (region)
      RG_SW:      rd_mux = {31'd0, msip_o[hart]};
      RG_CMP_LO:  rd_mux = cmp_q[hart][31:0];
      RG_CMP_HI:  rd_mux = cmp_q[hart][63:32];
      RG_TIME_LO: rd_mux = time_q[31:0];
      RG_TIME_HI: rd_mux = time_q[63:32];
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rdata_o     <= rd ? rd_mux : 32'd0;
    end
  end

  // R9
  rsp_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R9
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && region == RG_NONE) |=> rdata_o == 32'd0);
endmodule

// File: tb/core_timer_irq_test.sv
module core_timer_irq_test;
  localparam int unsigned N   = 2;
  localparam int unsigned SWB = 32'h0000;
  localparam int unsigned CMB = 32'h4000;
  localparam int unsigned TMB = 32'hBFF8;
  localparam int unsigned PS  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid;
  logic [31:0] rdata;
  logic [N-1:0] msip, mtip;

  int unsigned checks = 0, fails = 0;
  bit          done = 1'b0;
  logic [63:0] cyc;
  logic        msip_m [N];
  logic [63:0] cmp_m  [N];

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 64'd1;

  core_timer_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rdata_o(rdata),
    .msip_o(msip), .mtip_o(mtip)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] now_time();
    return (cyc - 64'd1) / PS;
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    logic [31:0] a32 = 32'(a);
    if (a32[1:0] != 0) return 0;
    if (a32 < SWB + 4 * N) return {31'd0, msip_m[(a32 - SWB) >> 2]};
    if (a32 >= CMB && a32 < CMB + 8 * N)
      return a32[2] ? cmp_m[(a32 - CMB) >> 3][63:32] : cmp_m[(a32 - CMB) >> 3][31:0];
    if (a32 == TMB)     return now_time()[31:0];
    if (a32 == TMB + 4) return now_time()[63:32];
    return 0;
  endfunction

  task automatic bus(input bit w, input logic [15:0] a, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (w) begin
      if (32'(a) < SWB + 4 * N && a[1:0] == 0) msip_m[(32'(a) - SWB) >> 2] = (d != 0);
      else if (32'(a) >= CMB && 32'(a) < CMB + 8 * N && a[1:0] == 0) begin
        if (a[2]) cmp_m[(32'(a) - CMB) >> 3][63:32] = d;
        else      cmp_m[(32'(a) - CMB) >> 3][31:0]  = d;
      end
    end
    chk(rsp_valid == 1'b1, "R9 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rdata == (w ? 32'd0 : exp_read(a)), w ? "R9 rdata after write" : "R8/R4/R6 read data",
        64'(rdata), 64'(w ? 32'd0 : exp_read(a)));
    for (int h = 0; h < N; h++)
      chk(msip[h] == msip_m[h], "R2/R3 msip_o", 64'(msip[h]), 64'(msip_m[h]));
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp idle", 64'(rsp_valid), 64'd0);
    for (int h = 0; h < N; h++)
      chk(mtip[h] == (now_time() >= cmp_m[h]), "R5 mtip_o", 64'(mtip[h]),
          64'(now_time() >= cmp_m[h]));
  endtask

  initial begin
    logic [15:0] bad [6];
    bad[0] = 16'h0008; bad[1] = 16'h0002; bad[2] = 16'h4010;
    bad[3] = 16'h4006; bad[4] = 16'hBFF9; bad[5] = 16'h2000;
    void'($urandom(32'd4242));
    for (int h = 0; h < N; h++) begin msip_m[h] = 1'b0; cmp_m[h] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(msip == '0, "R1 msip reset", 64'(msip), 64'd0);
    chk(rsp_valid == 1'b0, "R1 rsp reset", 64'(rsp_valid), 64'd0);
    bus(1'b0, 16'(TMB), 0);
    bus(1'b0, 16'(CMB), 0);
    bus(1'b0, 16'(CMB + 12), 0);
    bus(1'b0, 16'(SWB + 4), 0);
    // R2 R3 per-hart software bits
    bus(1'b1, 16'(SWB + 4), 32'h8000_0000);
    bus(1'b0, 16'(SWB + 4), 0);
    bus(1'b0, 16'(SWB), 0);
    bus(1'b1, 16'(SWB + 4), 0);
    // R4 halves
    bus(1'b1, 16'(CMB + 4), 32'hDEAD_BEEF);
    bus(1'b1, 16'(CMB), 32'h1234_5678);
    bus(1'b0, 16'(CMB + 4), 0);
    bus(1'b0, 16'(CMB), 0);
    // R5 future compare, then watch the rise
    bus(1'b1, 16'(CMB + 4), 0);
    bus(1'b1, 16'(CMB), 32'(now_time() + 64'd6));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(mtip[0] == (now_time() >= cmp_m[0]), "R5 mtip rise", 64'(mtip[0]),
          64'(now_time() >= cmp_m[0]));
    end
    // R7 time writes ignored
    bus(1'b1, 16'(TMB), 32'hFFFF_FFFF);
    bus(1'b1, 16'(TMB + 4), 32'hFFFF_FFFF);
    bus(1'b0, 16'(TMB), 0);
    bus(1'b0, 16'(TMB + 4), 0);
    // R6 time advance
    repeat (23) @(negedge clk);
    bus(1'b0, 16'(TMB), 0);
    // R8 unmapped
    for (int i = 0; i < 6; i++) begin
      bus(1'b1, bad[i], 32'hFFFF_FFFF);
      bus(1'b0, bad[i], 0);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom % 6;
      int unsigned h  = $urandom % N;
      case (op)
        0: bus(1'b1, 16'(SWB + 4 * h), ($urandom % 2 == 0) ? 32'd0 : $urandom);
        1: bus(1'b1, 16'(CMB + 8 * h),
               32'(now_time() + 64'($urandom % 20) - 64'd10));
        2: bus(1'b1, 16'(CMB + 8 * h + 4), ($urandom % 4 == 0) ? $urandom : 32'd0);
        3: bus(1'b0, 16'(CMB + 8 * h + 4 * ($urandom % 2)), 0);
        4: bus(1'b0, ($urandom % 2 == 0) ? 16'(SWB + 4 * h) : 16'(TMB + 4 * ($urandom % 2)), 0);
        default: bus($urandom % 2 == 1, bad[$urandom % 6], $urandom);
      endcase
    end
    for (int h = 0; h < N; h++) begin
      bus(1'b0, 16'(SWB + 4 * h), 0);
      bus(1'b0, 16'(CMB + 8 * h), 0);
      bus(1'b0, 16'(CMB + 8 * h + 4), 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule